// File: doc/BRIEF.md
# Level-Mirroring Maskable Interrupt Controller

This block gathers 32 level-sensitive interrupt lines into a single request line for a processor. Each line is brought into the local clock domain through a two-flop synchronizer. A pending register then copies the synchronized levels. Nothing is latched: when a source drops its line, its pending bit clears again. Software enables sources one by one through a mask register. The request output is high whenever any source that is both enabled and pending exists.

Software reaches the block over a simple single-cycle register bus with 32-bit words. The mask can be written and read back. The pending state can be read. Two further offsets accept writes and do nothing with them. Every other offset reads as zero and drops its writes. Priority, vectoring and edge capture are left to other logic.

Top module: `irq_mirror_ctrl`

## Requirements
- R1: Each pending bit follows its input level in both directions. A change on an input that is held steady appears in the pending register after the third rising clock edge, counting the edge that first samples it.
- R2: `req_out` is a register. After each rising edge it equals the OR-reduction of (mask AND pending) as those registers stood just before that edge.
- R3: The mask register is at byte address 0x04. All 32 bits are written by a bus write and read back unchanged by a bus read.
- R4: A read at byte address 0x0C returns the pending register.
- R5: Writes to byte addresses 0x00 and 0x14 are accepted but change neither the mask nor the request.
- R6: A read at any address other than 0x04 and 0x0C returns zero. A write to any address other than 0x00, 0x04 and 0x14 is ignored. The whole 8-bit address is decoded, so an address that is not word-aligned, such as 0x05, is unmapped.
- R7: The active-low reset clears the mask, the pending register, the synchronizer and the request, so `req_out` is 0 and both registers read as zero after reset.
- R8: Read data appears on `bus_rdata` one cycle after a read request (`bus_valid`=1, `bus_we`=0) and holds the register value sampled in the request cycle. In every cycle that follows a cycle with no read request, `bus_rdata` is zero.
- R9: When a mask write and a pending-register update land on the same clock edge, both take effect. The request on the following cycle reflects the combined new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt sources, asynchronous |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| req_out | output | 1 | Interrupt request to the processor |

## Verification
The bench measures the latency from input to request edge by edge, in both directions. A design with one synchronizer stage too many or too few raises or drops the request a cycle late or early. It also lets a mask write and a pending update land on the same edge. A design that lets one update override the other leaves the request low when it should rise. Writes to the accepted no-op offsets, to unmapped offsets and to the unaligned address 0x05 must leave the mask intact. Reads there, and idle cycles, must give zero. A decoder that looks at the low address bits loosely corrupts the mask or leaks register data. A random phase of mixed traffic is then checked against a behavioural model on every clock.

// File: rtl/irqm_pkg.sv
`timescale 1ns/1ps
package irqm_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t OFS_LEVEL = 8'h00;
  localparam addr_t OFS_MASK  = 8'h04;
  localparam addr_t OFS_PEND  = 8'h0C;
  localparam addr_t OFS_CTRL  = 8'h14;

  typedef enum logic [1:0] {
    WK_MASK   = 2'd0,
    WK_NOP    = 2'd1,
    WK_IGNORE = 2'd2
  } wr_kind_e;

  function automatic wr_kind_e classify_write(addr_t a);
    case (a)
      OFS_MASK:           return WK_MASK;
      OFS_LEVEL, OFS_CTRL: return WK_NOP;
      default:            return WK_IGNORE;
    endcase
  endfunction

  function automatic word_t read_select(addr_t a, word_t mask, word_t pend);
    case (a)
      OFS_MASK: return mask;
      OFS_PEND: return pend;
      default:  return '0;
    endcase
  endfunction

  function automatic logic any_active(word_t mask, word_t pend);
    return |(mask & pend);
  endfunction
endpackage

// File: rtl/irqm_level_track.sv
`timescale 1ns/1ps
module irqm_level_track #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= lvl_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= stage_q[STAGES-1];
  end
endmodule

// File: rtl/irqm_regs.sv
`timescale 1ns/1ps
module irqm_regs
  import irqm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bus_valid,
  input  logic  bus_we,
  input  addr_t bus_addr,
  input  word_t bus_wdata,
  input  word_t pend_q,
  output word_t mask_q,
  output word_t rdata_q,
  output logic  mask_wr_evt,
  output logic  nop_wr_evt,
  output logic  rd_evt
);
  wr_kind_e kind;

  assign kind        = classify_write(bus_addr);
  assign mask_wr_evt = bus_valid && bus_we && (kind == WK_MASK);
  assign nop_wr_evt  = bus_valid && bus_we && (kind == WK_NOP);
  assign rd_evt      = bus_valid && !bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (mask_wr_evt) mask_q <= bus_wdata;
      rdata_q <= rd_evt ? read_select(bus_addr, mask_q, pend_q) : '0;
    end
  end
endmodule

// File: rtl/irqm_req.sv
`timescale 1ns/1ps
module irqm_req
  import irqm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t mask_q,
  input  word_t pend_q,
  output logic  req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= any_active(mask_q, pend_q);
  end
endmodule

// File: rtl/irq_mirror_ctrl.sv
`timescale 1ns/1ps
module irq_mirror_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_in,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        req_out
);
  import irqm_pkg::*;

  word_t pend_q;
  word_t mask_q;
  logic  mask_wr_evt;
  logic  nop_wr_evt;
  logic  rd_evt;

  irqm_level_track #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (irq_in),
    .pend_q (pend_q)
  );

  irqm_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .pend_q      (pend_q),
    .mask_q      (mask_q),
    .rdata_q     (bus_rdata),
    .mask_wr_evt (mask_wr_evt),
    .nop_wr_evt  (nop_wr_evt),
    .rd_evt      (rd_evt)
  );

  irqm_req u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask_q (mask_q),
    .pend_q (pend_q),
    .req_q  (req_out)
  );
endmodule

// File: rtl/irqm_checker.sv
`timescale 1ns/1ps
module irqm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] irq_in,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        req_out,
  input logic [31:0] mask_q,
  input logic [31:0] pend_q,
  input logic        mask_wr_evt,
  input logic        nop_wr_evt,
  input logic        rd_evt
);
  logic [1:0] live_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_cyc <= 2'd0;
    else if (live_cyc != 2'd3) live_cyc <= live_cyc + 2'd1;
  end

  // R1
  pend_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cyc == 2'd3) |-> (pend_q == $past(irq_in, 3)));

  // R2
  req_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (req_out == $past((mask_q & pend_q) != 32'd0)));

  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 8'h04) |=> (mask_q == $past(bus_wdata)));

  // R5
  nop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nop_wr_evt |=> $stable(mask_q));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_evt |=> $stable(mask_q));

  // R4
  rd_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && bus_addr == 8'h0C) |=> (bus_rdata == $past(pend_q)));

  // R3
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && bus_addr == 8'h04) |=> (bus_rdata == $past(mask_q)));

  // R6
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr != 8'h04 && bus_addr != 8'h0C) |=> (bus_rdata == 32'd0));

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_we) |=> (bus_rdata == 32'd0));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!req_out && mask_q == 32'd0 && pend_q == 32'd0));
endmodule

bind irq_mirror_ctrl irqm_checker u_irqm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_in      (irq_in),
  .bus_valid   (bus_valid),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .req_out     (req_out),
  .mask_q      (mask_q),
  .pend_q      (pend_q),
  .mask_wr_evt (mask_wr_evt),
  .nop_wr_evt  (nop_wr_evt),
  .rd_evt      (rd_evt)
);

// File: tb/test_irq_mirror_ctrl.sv
`timescale 1ns/1ps
module test_irq_mirror_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_mirror_ctrl i_irq_mirror_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_valid(valid), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .req_out(req)
  );

  always #10 clk = ~clk;

  // Behavioural reference: input history queue, mask, pending, outputs
  logic [31:0] hist[$];
  logic [31:0] m_mask = '0, m_pend = '0, m_rd = '0;
  logic        m_req = 1'b0;

  always @(posedge clk) begin
    logic [31:0] nrd;
    logic        nreq;
    if (!rst_n) begin
      hist = {32'd0, 32'd0};
      m_mask = '0; m_pend = '0; m_rd = '0; m_req = 1'b0;
    end else begin
      nreq = (m_mask & m_pend) != 0;
      nrd = 32'd0;
      if (valid && !we) begin
        if (addr == 8'h04)      nrd = m_mask;
        else if (addr == 8'h0C) nrd = m_pend;
      end
      if (valid && we && addr == 8'h04) m_mask = wdata;
      hist.push_back(irq);
      m_pend = hist.pop_front();
      m_req = nreq;
      m_rd = nrd;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2 request, R8 read data)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model req", {31'd0, req}, {31'd0, m_req});
      chk("R8 model rdata", rdata, m_rd);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); d = rdata; valid = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0] alist [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h05, 8'hFC};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7 req after reset", {31'd0, req}, 32'd0);
    bus_rd(8'h04, v); chk("R7 mask after reset", v, 32'd0);
    bus_rd(8'h0C, v); chk("R7 pend after reset", v, 32'd0);

    // R3 full-width mask write and readback
    bus_wr(8'h04, 32'hA5A5_F00F);
    bus_rd(8'h04, v); chk("R3 mask readback", v, 32'hA5A5_F00F);
    // R8 idle cycle after a read gives zero
    @(negedge clk); chk("R8 idle rdata", rdata, 32'd0);

    // R1 latency, rising: enable bit 8 only, raise irq[8]
    bus_wr(8'h04, 32'h0000_0100);
    irq = 32'h0000_0100;
    repeat (3) @(negedge clk);
    chk("R1 req still low after 3 edges", {31'd0, req}, 32'd0);
    @(negedge clk);
    chk("R1 req high after 4 edges", {31'd0, req}, 32'd1);
    // R1 latency, falling
    irq = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 req still high after 3 edges", {31'd0, req}, 32'd1);
    @(negedge clk);
    chk("R1 req low after 4 edges", {31'd0, req}, 32'd0);

    // R4 pending readback follows levels
    irq = 32'h8000_0001; settle();
    bus_rd(8'h0C, v); chk("R4 pend pattern A", v, 32'h8000_0001);
    irq = 32'h0F0F_0000; settle();
    bus_rd(8'h0C, v); chk("R4 pend pattern B", v, 32'h0F0F_0000);
    // R2 masked vs unmasked
    chk("R2 no enabled source", {31'd0, req}, 32'd0);
    bus_wr(8'h04, 32'h0001_0000); @(negedge clk);
    chk("R2 enabled pending source", {31'd0, req}, 32'd1);

    // R5 no-op writes keep mask and request
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h14, 32'h0000_0000);
    bus_rd(8'h04, v); chk("R5 mask after no-op writes", v, 32'h0001_0000);
    chk("R5 req after no-op writes", {31'd0, req}, 32'd1);

    // R6 unmapped writes and reads
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h05, 32'h0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h04, v); chk("R6 mask after unmapped writes", v, 32'h0001_0000);
    bus_rd(8'h00, v); chk("R6 read 0x00", v, 32'd0);
    bus_rd(8'h14, v); chk("R6 read 0x14", v, 32'd0);
    bus_rd(8'h0D, v); chk("R6 read 0x0D", v, 32'd0);
    bus_rd(8'hFC, v); chk("R6 read 0xFC", v, 32'd0);

    // R9 mask write and pending update on the same edge
    bus_wr(8'h04, 32'h0);
    irq = 32'h0000_0020;
    @(negedge clk); @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = 8'h04; wdata = 32'h0000_0020;
    @(negedge clk); valid = 1'b0; we = 1'b0;
    chk("R9 req before combined update", {31'd0, req}, 32'd0);
    @(negedge clk);
    chk("R9 req after combined update", {31'd0, req}, 32'd1);
    bus_rd(8'h0C, v); chk("R9 pend after combined update", v, 32'h0000_0020);

    // Random traffic, checked by the model each cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) irq = $urandom();
      valid = $urandom_range(0, 1) == 1;
      we = $urandom_range(0, 1) == 1;
      addr = alist[$urandom_range(0, 7)];
      wdata = $urandom();
    end
    @(negedge clk); valid = 1'b0;
    settle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule